// File: doc/BRIEF.md
# Store-Multiple Register Sequencer

This block copies a run of consecutive general registers into consecutive words, one word per cycle. A single-cycle `start` pulse supplies three values: the first register number, a 4-bit count taken from the condition code, and a word base address. The block latches all three at that edge. It then reads the external 16-entry register file through a combinational read port. Register numbers advance modulo 16, and target addresses advance modulo the address width.

Each target word is routed according to its full address value. A word whose address is below 16 is written back into the register file at that index. Any other word is offered on a valid/ready memory write port. While `mem_valid` is high and `mem_ready` is low, the block holds the word and the address and does not advance. Each memory word is checked against a per-word fault input before it is written. A fault ends the run at once with a trap pulse. A run with no fault ends with a done pulse.

Top module: `regstore_seq`

## Requirements
- R1: The number of words written equals the latched 4-bit count, and a count of 0 writes all 16 registers.
- R2: Word k of a run (k counting from 0) carries register (first + k) mod 16 and targets address (base + k) mod 2^AW.
- R3: A target whose full address is below 16 is written to the register file at index address[3:0], with `mem_valid` low. Any other target goes to the memory port, with `rf_wr_en` low.
- R4: A memory word is taken only in a cycle where `mem_valid` and `mem_ready` are both high. While `mem_ready` is low, `mem_addr` holds steady and no word is lost or repeated. With `mem_ready` held high, one word is written per cycle.
- R5: When `mem_fault` is high for the current memory target, that word is not written and no later word is written. `trap` then pulses for one cycle in the next cycle, and `done` does not pulse.
- R6: After the last word is written, `done` pulses for exactly one cycle in the next cycle, and `busy` is low in that cycle.
- R7: A `start` that arrives while `busy` is high is ignored. Changes to `start_reg`, `cc_count` or `base_addr` after the start edge do not affect the run in progress.
- R8: While reset is active, `busy`, `done`, `trap`, `mem_valid` and `rf_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; accepted only while idle |
| start_reg | input | 4 | First register number |
| cc_count | input | 4 | Register count taken from the condition code (0 means 16) |
| base_addr | input | AW | Word address of the first target |
| rf_rd_idx | output | 4 | Register file read index |
| rf_rd_data | input | DW | Register file read data, combinational from rf_rd_idx |
| rf_wr_en | output | 1 | Register file write enable (low-address target) |
| rf_wr_idx | output | 4 | Register file write index |
| rf_wr_data | output | DW | Register file write data |
| mem_valid | output | 1 | Memory write word valid |
| mem_ready | input | 1 | Memory accepts the word this cycle |
| mem_addr | output | AW | Memory word address |
| mem_data | output | DW | Memory write data |
| mem_fault | input | 1 | Protection or nonexistent-memory fault for mem_addr |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: run completed |
| trap | output | 1 | One-cycle pulse: run aborted on a fault |

## Verification
The bench first runs a count of zero that starts at register 14. A decoder that treats zero literally writes nothing, and one that does not wrap register numbers reads the wrong registers after 15. A base address near the top of the address space wraps into the register-file window. A design that compares only the low address bits sends early words to the wrong place, and one that does not wrap the address writes the last word to memory. Runs with alternating back-pressure catch any design that advances on `valid` alone or writes a word twice. A fault in the middle of a run, and a second `start` issued while busy with different operands, catch designs that keep writing after the fault, or that reload their counters mid-run.

// File: rtl/regstore_pkg.sv
package regstore_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/regstore_ctrl.sv
module regstore_ctrl
  import regstore_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 16,
  localparam int RIW = $clog2(NREG),
  localparam int CW  = RIW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [RIW-1:0] start_reg,
  input  logic [RIW-1:0] cc_count,
  input  logic [AW-1:0]  base_addr,
  input  logic           step,
  input  logic           abort,
  output logic           busy,
  output logic [RIW-1:0] cur_reg,
  output logic [AW-1:0]  cur_addr,
  output logic           done,
  output logic           trap
);
  seq_state_t     state_q;
  logic [RIW-1:0] reg_q;
  logic [AW-1:0]  addr_q;
  logic [CW-1:0]  left_q;
  logic           done_q;
  logic           trap_q;
  logic [CW-1:0]  load_count;

  // A zero count stands for the whole register file.
  always_comb begin
    if (cc_count == '0) load_count = CW'(NREG);
    else                load_count = {1'b0, cc_count};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      reg_q   <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            reg_q   <= start_reg;
            addr_q  <= base_addr;
            left_q  <= load_count;
          end
        end
        ST_RUN: begin
          if (abort) begin
            state_q <= ST_IDLE;
            trap_q  <= 1'b1;
          end else if (step) begin
            reg_q  <= reg_q + 1'b1;
            addr_q <= addr_q + 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == CW'(1)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q == ST_RUN);
  assign cur_reg  = reg_q;
  assign cur_addr = addr_q;
  assign done     = done_q;
  assign trap     = trap_q;
endmodule

// File: rtl/regstore_route.sv
module regstore_route #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           busy,
  input  logic [RIW-1:0] cur_reg,
  input  logic [AW-1:0]  cur_addr,
  input  logic [DW-1:0]  rf_rd_data,
  input  logic           mem_ready,
  input  logic           mem_fault,
  output logic [RIW-1:0] rf_rd_idx,
  output logic           rf_wr_en,
  output logic [RIW-1:0] rf_wr_idx,
  output logic [DW-1:0]  rf_wr_data,
  output logic           mem_valid,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_data,
  output logic           step,
  output logic           abort
);
  logic to_rf;
  logic to_mem;

  // The full address decides the target, not just its low bits.
  assign to_rf  = (cur_addr < AW'(NREG));
  assign to_mem = busy && !to_rf;

  assign rf_rd_idx  = cur_reg;
  assign rf_wr_en   = busy && to_rf;
  assign rf_wr_idx  = cur_addr[RIW-1:0];
  assign rf_wr_data = rf_rd_data;

  assign mem_valid  = to_mem && !mem_fault;
  assign mem_addr   = cur_addr;
  assign mem_data   = rf_rd_data;

  assign abort = to_mem && mem_fault;
  assign step  = (busy && to_rf) || (to_mem && mem_ready && !mem_fault);
endmodule

// File: rtl/regstore_seq.sv
module regstore_seq #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [RIW-1:0] start_reg,
  input  logic [RIW-1:0] cc_count,
  input  logic [AW-1:0]  base_addr,
  output logic [RIW-1:0] rf_rd_idx,
  input  logic [DW-1:0]  rf_rd_data,
  output logic           rf_wr_en,
  output logic [RIW-1:0] rf_wr_idx,
  output logic [DW-1:0]  rf_wr_data,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_data,
  input  logic           mem_fault,
  output logic           busy,
  output logic           done,
  output logic           trap
);
  logic [RIW-1:0] cur_reg;
  logic [AW-1:0]  cur_addr;
  logic           step;
  logic           abort;

  regstore_ctrl #(.AW(AW), .NREG(NREG)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_reg (start_reg),
    .cc_count  (cc_count),
    .base_addr (base_addr),
    .step      (step),
    .abort     (abort),
    .busy      (busy),
    .cur_reg   (cur_reg),
    .cur_addr  (cur_addr),
    .done      (done),
    .trap      (trap)
  );

  regstore_route #(.AW(AW), .DW(DW), .NREG(NREG)) u_route (
    .busy       (busy),
    .cur_reg    (cur_reg),
    .cur_addr   (cur_addr),
    .rf_rd_data (rf_rd_data),
    .mem_ready  (mem_ready),
    .mem_fault  (mem_fault),
    .rf_rd_idx  (rf_rd_idx),
    .rf_wr_en   (rf_wr_en),
    .rf_wr_idx  (rf_wr_idx),
    .rf_wr_data (rf_wr_data),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .step       (step),
    .abort      (abort)
  );
endmodule

// File: rtl/regstore_sva.sv
module regstore_sva #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int RIW = $clog2(NREG)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [RIW-1:0] start_reg,
  input logic [RIW-1:0] cc_count,
  input logic [AW-1:0]  base_addr,
  input logic [RIW-1:0] rf_rd_idx,
  input logic [DW-1:0]  rf_rd_data,
  input logic           rf_wr_en,
  input logic [RIW-1:0] rf_wr_idx,
  input logic [DW-1:0]  rf_wr_data,
  input logic           mem_valid,
  input logic           mem_ready,
  input logic [AW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_data,
  input logic           mem_fault,
  input logic           busy,
  input logic           done,
  input logic           trap
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && rf_wr_en)); // R3

  AST_MEM_ABOVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr >= AW'(NREG))); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> $stable(mem_addr)); // R4

  AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (!done && !busy && !mem_valid && !rf_wr_en)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)); // R6

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && !rf_wr_en)); // R7

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!busy && !done && !trap); // R8
    end
  end
endmodule

bind regstore_seq regstore_sva #(.AW(AW), .DW(DW), .NREG(NREG)) u_sva (.*);

// File: tb/test_regstore_seq.sv
module test_regstore_seq;
  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    start_reg = '0;
  logic [3:0]    cc_count = '0;
  logic [AW-1:0] base_addr = '0;
  logic [3:0]    rf_rd_idx;
  logic [DW-1:0] rf_rd_data;
  logic          rf_wr_en;
  logic [3:0]    rf_wr_idx;
  logic [DW-1:0] rf_wr_data;
  logic          mem_valid;
  logic          mem_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic          mem_fault;
  logic          busy, done, trap;

  logic [DW-1:0] rf_m [16];
  logic [DW-1:0] snap [16];
  logic [AW-1:0] la [64];
  logic [DW-1:0] ld [64];
  int            nw = 0;
  int            n_checks = 0;
  int            n_fail = 0;
  int            n_done, n_trap;
  logic          stall_mode = 1'b0;
  logic          tog = 1'b0;
  logic          fault_en = 1'b0;
  logic [AW-1:0] fault_addr = '0;

  always #(CLK_P/2) clk = ~clk;

  assign rf_rd_data = rf_m[rf_rd_idx];
  assign mem_fault  = fault_en && (mem_addr == fault_addr);

  regstore_seq #(.AW(AW), .DW(DW), .NREG(16)) i_regstore_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_reg(start_reg),
    .cc_count(cc_count), .base_addr(base_addr), .rf_rd_idx(rf_rd_idx),
    .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx),
    .rf_wr_data(rf_wr_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_fault(mem_fault),
    .busy(busy), .done(done), .trap(trap)
  );

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (nw < 64) begin
        la[nw] = mem_addr;
        ld[nw] = mem_data;
      end
      nw = nw + 1;
    end
    if (rf_wr_en) rf_m[rf_wr_idx] = rf_wr_data;
  end

  always @(negedge clk) begin
    tog = ~tog;
    mem_ready = stall_mode ? tog : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill_rf(input logic [DW-1:0] seed);
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      rf_m[i] = seed + DW'(i) * 32'h0101_0101;
      snap[i] = rf_m[i];
    end
    nw = 0;
  endtask

  // Pulse start, then scramble the operand inputs (R7).
  task automatic launch(input logic [3:0] r, input logic [3:0] c, input logic [AW-1:0] b);
    @(negedge clk);
    start = 1'b1; start_reg = r; cc_count = c; base_addr = b;
    @(negedge clk);
    start = 1'b0; start_reg = ~r; cc_count = c + 4'd5; base_addr = b ^ 16'h0F0F;
  endtask

  task automatic wait_end();
    int tail;
    n_done = 0; n_trap = 0; tail = -1;
    for (int i = 0; i < 400 && tail != 0; i++) begin
      if (done) n_done++;
      if (trap) n_trap++;
      if (tail > 0) tail--;
      if (tail < 0 && (done || trap)) tail = 4;
      if (tail != 0) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !trap, "R8 status idle", {busy, done, trap}, 0);
    chk(!mem_valid && !rf_wr_en, "R8 no writes", {mem_valid, rf_wr_en}, 0);
  endtask

  task automatic t_basic();
    fill_rf(32'hA000_0000);
    launch(4'd3, 4'd4, 16'h0100);
    wait_end();
    chk(nw == 4, "R1 count 4", nw, 4);
    for (int k = 0; k < 4; k++) begin
      chk(la[k] == 16'h0100 + AW'(k), "R2 address", la[k], 16'h0100 + k);
      chk(ld[k] == snap[3 + k], "R2 data", ld[k], snap[3 + k]);
    end
    chk(n_done == 1 && n_trap == 0, "R6 one done pulse", n_done, 1);
  endtask

  task automatic t_zero_wrap_stall();
    fill_rf(32'h1234_0000);
    stall_mode = 1'b1;
    launch(4'd14, 4'd0, 16'h0200);
    wait_end();
    stall_mode = 1'b0;
    chk(nw == 16, "R1 zero means sixteen", nw, 16);
    chk(nw == 16, "R4 no lost or repeated word under stall", nw, 16);
    for (int k = 0; k < 16; k++) begin
      chk(la[k] == 16'h0200 + AW'(k), "R2 address", la[k], 16'h0200 + k);
      chk(ld[k] == snap[(14 + k) % 16], "R2 register wrap", ld[k], snap[(14 + k) % 16]);
    end
    chk(n_done == 1, "R6 done after stalled run", n_done, 1);
  endtask

  task automatic t_addr_wrap();
    fill_rf(32'h5500_0000);
    launch(4'd5, 4'd3, 16'hFFFE);
    wait_end();
    chk(nw == 2, "R3 two memory words", nw, 2);
    chk(la[0] == 16'hFFFE && la[1] == 16'hFFFF, "R2 top addresses", {la[0], la[1]}, 32'hFFFEFFFF);
    chk(rf_m[0] == snap[7], "R3 wrapped word lands in register 0", rf_m[0], snap[7]);
  endtask

  task automatic t_reg_target();
    fill_rf(32'h7700_0000);
    launch(4'd10, 4'd3, 16'h0004);
    wait_end();
    chk(nw == 0, "R3 no memory write", nw, 0);
    for (int k = 0; k < 3; k++)
      chk(rf_m[4 + k] == snap[10 + k], "R3 register target", rf_m[4 + k], snap[10 + k]);
    chk(rf_m[7] == snap[7], "R3 neighbour untouched", rf_m[7], snap[7]);
    chk(n_done == 1, "R6 done after register run", n_done, 1);
  endtask

  task automatic t_fault();
    fill_rf(32'h3300_0000);
    fault_addr = 16'h0302;
    fault_en = 1'b1;
    launch(4'd0, 4'd6, 16'h0300);
    wait_end();
    fault_en = 1'b0;
    chk(nw == 2, "R5 writes stop at fault", nw, 2);
    chk(n_trap == 1 && n_done == 0, "R5 trap not done", {n_trap[7:0], n_done[7:0]}, 16'h0100);
    chk(!busy, "R5 idle after trap", busy, 0);
  endtask

  task automatic t_busy_start();
    fill_rf(32'h4400_0000);
    launch(4'd1, 4'd5, 16'h0400);
    @(negedge clk);
    start = 1'b1; start_reg = 4'd8; cc_count = 4'd2; base_addr = 16'h0500;
    @(negedge clk);
    start = 1'b0;
    wait_end();
    chk(nw == 5, "R7 start while busy ignored", nw, 5);
    chk(la[4] == 16'h0404 && ld[4] == snap[5], "R7 latched operands", la[4], 16'h0404);
    chk(n_done == 1, "R6 single done", n_done, 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) rf_m[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic();
    t_zero_wrap_stall();
    t_addr_wrap();
    t_reg_target();
    t_fault();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule